// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Write Sequencer

This block sits behind the serial command decoder of a small byte-addressed non-volatile memory. When the decoder recognises a write command it pulses `cmd_start` with the target address. Each data byte that follows arrives on `byte_valid`/`byte_data` and is stored in a page buffer. The first byte goes to the given offset, and each later byte goes to the next offset. After the last offset of the page the buffer wraps to offset zero of the same page, so a long burst overwrites the slots it filled first.

The decoder pulses `commit` when chip select rises on a byte boundary. If at least one byte has been buffered, the block starts a self-timed internal cycle. For the first half of `TW` clock cycles it erases every byte slot that was written, to 00h. For the remaining cycles it programs those slots with the buffered values. Slots that were not written keep their stored contents. `busy` is high for exactly `TW` cycles, then `done` pulses for one cycle, which the decoder uses to clear its busy and write-enable status. While `busy` is high the block ignores every array access, byte and command input, and the cycle runs to its end.

The array model holds `DEPTH` bytes that come out of reset at FFh. A read request made while idle returns the addressed byte on the following cycle.

Top module: `page_write_seq`

## Requirements
- R1: After reset `busy` and `done` are 0 and every array byte reads FFh.
- R2: After `cmd_start` with address A, the first data byte goes to A and each later byte to the next higher address in the same page.
- R3: The page is PAGE bytes (default 16), the low log2(PAGE) address bits being the offset. A byte past the last offset wraps to offset 0 of the same page and replaces the byte buffered there. No other page changes.
- R4: A `commit` with no data byte buffered since the last `cmd_start` starts no cycle: `busy` stays 0 and the array is unchanged.
- R5: A `commit` accepted at a clock edge makes `busy` 1 for exactly TW cycles. In the cycle after the last busy cycle, `busy` is 0 and `done` is 1. `done` is 1 for exactly one cycle.
- R6: Only slots that received a byte in the current command are written. Other bytes of the page keep their stored values.
- R7: Each written byte is first erased to 00h and then programmed, so it ends equal to the new value whatever it held before.
- R8: While `busy` is 1, `byte_valid`, `cmd_start`, `commit` and `rd_req` have no effect. `rd_data` holds its value, and the cycle completes normally.
- R9: `cmd_start` clears the record of written slots, so bytes given before a later `cmd_start` are never written to the array.
- R10: `rd_req` while idle puts the byte at `rd_addr` on `rd_data` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start of a write command; loads the start address |
| start_addr | input | AW | Byte address of the first data byte |
| byte_valid | input | 1 | One data byte present on byte_data |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | Valid chip-select rise at a byte boundary |
| rd_req | input | 1 | Array read request |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Internal write cycle in progress |
| done | output | 1 | One-cycle pulse when the cycle ends |

## Verification
The bench builds the block with DEPTH=64, PAGE=16 and TW=6. With only four pages, it can check that a write in one page leaves the neighbouring pages untouched. With a short busy window, every cycle of busy can be sampled, and inputs can be injected into the middle of a cycle. A 17-byte burst that starts at offset 14 wraps the page and overwrites the first slot, and an old value of A0h replaced by 0Fh shows whether an erase came before the program.

// File: rtl/pws_pkg.sv
package pws_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_PROG  = 2'd2
    } phase_e;
endpackage

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
    parameter int AW   = 7,
    parameter int PAGE = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  busy,
    input  logic                  cmd_start,
    input  logic [AW-1:0]         start_addr,
    input  logic                  byte_valid,
    input  logic [7:0]            byte_data,
    output logic [AW-$clog2(PAGE)-1:0] page,
    output logic [PAGE-1:0]       mask,
    output logic [PAGE-1:0][7:0]  data,
    output logic                  has_data
);
    localparam int OW  = $clog2(PAGE);
    localparam int PGW = AW - OW;

    typedef struct packed {
        logic [PGW-1:0]       page;
        logic [OW-1:0]        off;
        logic [PAGE-1:0]      mask;
        logic [PAGE-1:0][7:0] data;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (!busy) begin
            if (cmd_start) begin
                buf_d.page = start_addr[AW-1:OW];
                buf_d.off  = start_addr[OW-1:0];
                buf_d.mask = '0;
            end else if (byte_valid) begin
                buf_d.data[buf_q.off] = byte_data;
                buf_d.mask[buf_q.off] = 1'b1;
                buf_d.off             = buf_q.off + 1'b1; // wraps inside page
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign page     = buf_q.page;
    assign mask     = buf_q.mask;
    assign data     = buf_q.data;
    assign has_data = |buf_q.mask;

    // R8: the written-slot record cannot change during a cycle
    p_mask_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(buf_q.mask));
    // R9: a new command starts with no slot recorded
    p_mask_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_start) |=> (buf_q.mask == '0));
endmodule

// File: rtl/pws_seq.sv
module pws_seq #(
    parameter int TW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic has_data,
    output logic busy,
    output logic done,
    output logic erase_go,
    output logic prog_go
);
    import pws_pkg::*;

    localparam int HALF = TW / 2;
    localparam int REST = TW - HALF;
    localparam int CW   = $clog2(TW);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        erase_go   = 1'b0;
        prog_go    = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (commit && has_data) begin
                    seq_d.ph  = PH_ERASE;
                    seq_d.cnt = '0;
                end
            end
            PH_ERASE: begin
                erase_go  = (seq_q.cnt == '0);
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt == CW'(HALF - 1)) begin
                    seq_d.ph  = PH_PROG;
                    seq_d.cnt = '0;
                end
            end
            PH_PROG: begin
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt == CW'(REST - 1)) begin
                    prog_go    = 1'b1;
                    seq_d.ph   = PH_IDLE;
                    seq_d.cnt  = '0;
                    seq_d.done = 1'b1;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, cnt: '0, done: 1'b0};
        else        seq_q <= seq_d;
    end

    assign busy = (seq_q.ph != PH_IDLE);
    assign done = seq_q.done;

    // checker: length of the current busy run
    logic [CW:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    initial begin
        if (TW < 2) $error("TW must be at least 2");
    end

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q == (CW+1)'(TW) && !busy));
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_empty_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && commit && !has_data) |=> !busy);
    p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> !prog_go);
endmodule

// File: rtl/pws_array.sv
module pws_array #(
    parameter int DEPTH = 128,
    parameter int PAGE  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  busy,
    input  logic                  erase_go,
    input  logic                  prog_go,
    input  logic [$clog2(DEPTH)-$clog2(PAGE)-1:0] wr_page,
    input  logic [PAGE-1:0]       wr_mask,
    input  logic [PAGE-1:0][7:0]  wr_data,
    input  logic                  rd_req,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [7:0]            rd_data
);
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rd_d, rd_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if ((i / PAGE) == int'(wr_page) && wr_mask[i % PAGE]) begin
                if (erase_go) mem_d[i] = 8'h00;
                if (prog_go)  mem_d[i] = wr_data[i % PAGE];
            end
        end
        rd_d = rd_q;
        if (rd_req && !busy) rd_d = mem_q[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
            rd_q <= 8'hFF;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    assign rd_data = rd_q;

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rd_data));
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
    parameter int DEPTH = 128,
    parameter int PAGE  = 16,
    parameter int TW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [AW-1:0] start_addr,
    input  logic          byte_valid,
    input  logic [7:0]    byte_data,
    input  logic          commit,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          done
);
    localparam int PGW = AW - $clog2(PAGE);

    logic [PGW-1:0]       pg;
    logic [PAGE-1:0]      mask;
    logic [PAGE-1:0][7:0] bdata;
    logic                 has_data;
    logic                 erase_go;
    logic                 prog_go;

    pws_page_buf #(.AW(AW), .PAGE(PAGE)) u_buf (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .page(pg), .mask(mask), .data(bdata), .has_data(has_data)
    );

    pws_seq #(.TW(TW)) u_seq (
        .clk(clk), .rst_n(rst_n), .commit(commit), .has_data(has_data),
        .busy(busy), .done(done), .erase_go(erase_go), .prog_go(prog_go)
    );

    pws_array #(.DEPTH(DEPTH), .PAGE(PAGE)) u_arr (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .erase_go(erase_go), .prog_go(prog_go),
        .wr_page(pg), .wr_mask(mask), .wr_data(bdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/page_write_seq_bench.sv
module page_write_seq_bench;
    localparam int DEPTH = 64;
    localparam int PAGE  = 16;
    localparam int TW    = 6;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 0, byte_valid = 0, commit = 0, rd_req = 0;
    logic [AW-1:0] start_addr = '0, rd_addr = '0;
    logic [7:0] byte_data = '0;
    logic [7:0] rd_data;
    logic busy, done;

    always #4 clk = ~clk;

    page_write_seq #(.DEPTH(DEPTH), .PAGE(PAGE), .TW(TW)) u_page_write_seq (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .commit(commit),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    typedef struct { int addr; logic [7:0] data; string tag; } exp_t;
    exp_t sb[$];
    logic fire = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compare a read one cycle after it was accepted
    always @(posedge clk) fire <= rd_req && !busy;
    always @(negedge clk) begin
        if (fire && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(rd_data === e.data, e.tag, rd_data, e.data);
        end
    end

    task automatic rd(int a, logic [7:0] exp, string tag);
        @(negedge clk);
        rd_req = 1; rd_addr = AW'(a);
        sb.push_back('{addr: a, data: exp, tag: tag});
        @(negedge clk);
        rd_req = 0;
        @(negedge clk);
    endtask

    task automatic start(int a);
        @(negedge clk);
        cmd_start = 1; start_addr = AW'(a);
        @(negedge clk);
        cmd_start = 0;
    endtask

    task automatic put(logic [7:0] d);
        byte_valid = 1; byte_data = d;
        @(negedge clk);
        byte_valid = 0;
    endtask

    // commit, then follow busy cycle by cycle; optional noise mid-cycle
    task automatic run(bit noise);
        logic [7:0] held;
        bit ok = 1;
        commit = 1;
        @(negedge clk);
        commit = 0;
        held = rd_data;
        for (int k = 0; k < TW; k++) begin
            if (busy !== 1'b1 || done !== 1'b0) ok = 0;
            if (noise && k == 1) begin
                byte_valid = 1; byte_data = 8'h99; cmd_start = 1;
                start_addr = AW'(9); commit = 1; rd_req = 1; rd_addr = AW'(3);
            end else begin
                byte_valid = 0; cmd_start = 0; commit = 0; rd_req = 0;
            end
            @(negedge clk);
            if (noise && rd_data !== held) ok = 0;
        end
        chk(ok, "R5 busy high for TW cycles", busy, 1);
        if (noise) chk(rd_data === held, "R8 rd_data held during busy", rd_data, held);
        chk(busy === 1'b0 && done === 1'b1, "R5 done after busy", {busy, done}, 1);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R5 done one cycle", {busy, done}, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy === 0 && done === 0, "R1 reset outputs", {busy, done}, 0);
        rd(0, 8'hFF, "R1 reset byte 0");
        rd(37, 8'hFF, "R10 reset byte 37");
        rd(63, 8'hFF, "R1 reset byte 63");

        // R2 / R6 sequential bytes
        start(3); put(8'hA0); put(8'hA1); put(8'hA2);
        run(0);
        rd(3, 8'hA0, "R2 first byte");
        rd(4, 8'hA1, "R2 second byte");
        rd(5, 8'hA2, "R2 third byte");
        rd(2, 8'hFF, "R6 slot below untouched");
        rd(6, 8'hFF, "R6 slot above untouched");

        // R3 wrap: 17 bytes from offset 14 of page 1
        start(30);
        for (int k = 0; k < 17; k++) put(8'(8'h40 + k));
        run(0);
        rd(30, 8'h50, "R3 wrap overwrote first slot");
        rd(31, 8'h41, "R3 last offset");
        rd(16, 8'h42, "R3 wrapped to page start");
        rd(29, 8'h4F, "R3 offset 13");
        rd(32, 8'hFF, "R3 next page untouched");
        rd(15, 8'hFF, "R3 previous page untouched");

        // R7 erase before program
        start(3); put(8'h0F);
        run(0);
        rd(3, 8'h0F, "R7 erase then program");
        rd(4, 8'hA1, "R6 neighbour kept");

        // R4 empty commit
        start(40);
        commit = 1;
        @(negedge clk);
        commit = 0;
        chk(busy === 1'b0, "R4 empty commit no busy", busy, 0);
        @(negedge clk);
        chk(busy === 1'b0, "R4 still idle", busy, 0);
        rd(40, 8'hFF, "R4 array unchanged");

        // R9 record cleared by new command
        start(48); put(8'h77);
        start(53); put(8'h55);
        run(0);
        rd(48, 8'hFF, "R9 abandoned byte not written");
        rd(53, 8'h55, "R9 new byte written");

        // R8 inputs ignored during busy
        start(8); put(8'h11);
        run(1);
        @(negedge clk);
        chk(busy === 1'b0, "R8 no second cycle", busy, 0);
        rd(8, 8'h11, "R8 cycle completed");
        rd(9, 8'hFF, "R8 byte during busy ignored");
        rd(3, 8'h0F, "R10 read after cycle");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule